// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Unit

This block runs programs for a stack machine, one instruction at a time. Arithmetic instructions name no operands. They always take the two entries at the top of an internal register stack and put one result back in their place. PUSH copies a word from a small external data memory onto the stack. POP moves the top entry back into that memory. An expression written in reverse Polish order therefore runs directly as a sequence of instructions. For example, PUSH a, PUSH b, SUB, PUSH c, DIV, POP x stores (a−b)/c at x.

Instructions arrive on a valid/ready handshake. The data memory is outside the block. Its read is combinational and its write takes effect on the clock edge that accepts the POP. All instructions except DIV finish on the edge that accepts them. DIV starts an iterative divider and keeps ready low until the quotient is on the stack.

The controller has two states. ST_IDLE accepts an instruction. The transition *div_start* goes from ST_IDLE to ST_DIVIDE when a DIV without a fault is accepted. ST_DIVIDE waits for the divider. The transition *div_commit* goes from ST_DIVIDE back to ST_IDLE on the edge that writes the quotient onto the stack. Every other instruction, and any DIV that faults, takes the self-loop *accept* in ST_IDLE.

Top module: `rpn_stack_unit`

## Requirements
- R1: After reset, tos is 0, in_ready is 1, busy is 0 and all three error flags are 0.
- R2: Opcode 3'd0 (PUSH) with fewer than DEPTH entries places mem_rdata, read at in_addr, on top of the stack. tos shows it after the accepting edge.
- R3: Opcode 3'd1 (POP) with at least one entry asserts mem_we for the accepting cycle, with mem_addr = in_addr and mem_wdata = tos, and removes the top entry.
- R4: Opcodes 3'd2 (ADD), 3'd3 (SUB) and 3'd4 (MULT) replace the top two entries with one result. The left operand is the entry second from top and the right operand is the top entry. The result keeps the low DATA_W bits.
- R5: Opcode 3'd5 (DIV) replaces the top two entries with (second ÷ top) as signed values, truncated toward zero and kept to DATA_W bits. After the accepting edge, in_ready stays low and busy stays high for exactly DATA_W+1 cycles.
- R6: A PUSH when the stack holds DEPTH entries raises err_overflow and changes neither the stack nor memory.
- R7: A POP on an empty stack, or an arithmetic opcode with fewer than two entries, raises err_underflow. It writes no memory and leaves the stack unchanged.
- R8: A DIV whose top entry is 0, with at least two entries present, raises err_divzero and leaves the stack unchanged.
- R9: The error flags are those of the most recently accepted instruction. At most one flag is set at a time, and an instruction without a fault clears them.
- R10: Opcodes 3'd6 and 3'd7 are accepted and have no effect on the stack, memory or flags (the flags are cleared).
- R11: The sequence PUSH a, PUSH b, SUB, PUSH c, DIV, POP x leaves (M[a]−M[b])/M[c] in M[x].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction |
| in_op | input | 3 | Opcode |
| in_addr | input | ADDR_W | Memory address for PUSH and POP |
| mem_addr | output | ADDR_W | Data memory address |
| mem_we | output | 1 | Data memory write strobe |
| mem_wdata | output | DATA_W | Data memory write data |
| mem_rdata | input | DATA_W | Data memory read data, combinational |
| tos | output | DATA_W | Top-of-stack value, 0 when the stack is empty |
| busy | output | 1 | Division in progress |
| err_overflow | output | 1 | Last instruction pushed onto a full stack |
| err_underflow | output | 1 | Last instruction had too few entries |
| err_divzero | output | 1 | Last instruction divided by zero |

## Verification
Most internal state is visible only through tos. If the entry count is wrong, the first visible effect may come several instructions later. The usual signs are a late or missing underflow or overflow flag, or a wrong value on tos once the stack is popped down to the damaged level. For this reason the scoreboard compares tos and all flags after every instruction, and it drains the stack completely after the overflow case. A fault in the divider shows only once its result is committed, DATA_W+1 cycles after acceptance. It appears as a wrong quotient or as a wrong ready-low count. A misdirected POP does not show until memory is read back, so the final memory image is compared word by word.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

    localparam logic [2:0] OPC_PUSH = 3'd0;
    localparam logic [2:0] OPC_POP  = 3'd1;
    localparam logic [2:0] OPC_ADD  = 3'd2;
    localparam logic [2:0] OPC_SUB  = 3'd3;
    localparam logic [2:0] OPC_MUL  = 3'd4;
    localparam logic [2:0] OPC_DIV  = 3'd5;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_DIVIDE = 1'b1
    } unit_state_t;

endpackage

// File: rtl/rpn_divider.sv
// Iterative signed divider: one quotient bit per cycle, truncating toward zero.
module rpn_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, den_q;
    logic [CW-1:0] cnt_q;
    logic          neg_q, run_q;
    logic [W-1:0]  mag_a, mag_b;
    logic [W:0]    trial;

    assign mag_a = dividend[W-1] ? (~dividend + 1'b1) : dividend;
    assign mag_b = divisor[W-1]  ? (~divisor + 1'b1)  : divisor;
    assign trial = {rem_q, quo_q[W-1]} - {1'b0, den_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            neg_q <= 1'b0;
            run_q <= 1'b0;
        end else if (start) begin
            rem_q <= '0;
            quo_q <= mag_a;
            den_q <= mag_b;
            cnt_q <= CW'(W);
            neg_q <= dividend[W-1] ^ divisor[W-1];
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q != '0) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= {rem_q[W-2:0], quo_q[W-1]};
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
            end else begin
                run_q <= 1'b0;
            end
        end
    end

    assign done     = run_q && (cnt_q == '0);
    assign quotient = neg_q ? (~quo_q + 1'b1) : quo_q;

endmodule

// File: rtl/rpn_stack.sv
// Register stack with push, pop and fold (replace top two with one value).
module rpn_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_en,
    input  logic                       pop_en,
    input  logic                       fold_en,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               top,
    output logic [W-1:0]               second,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     ent [DEPTH];
    logic [CNT_W-1:0] cm1, cm2;

    assign cm1 = count - 1'b1;
    assign cm2 = count - 2'd2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (push_en) begin
            count <= count + 1'b1;
        end else if (pop_en || fold_en) begin
            count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if ((push_en && count == CNT_W'(i)) ||
                (fold_en && count == CNT_W'(i + 2))) begin
                ent[i] <= wdata;
            end
        end
    end

    assign top    = (count >= CNT_W'(1)) ? ent[cm1[IDX_W-1:0]] : '0;
    assign second = (count >= CNT_W'(2)) ? ent[cm2[IDX_W-1:0]] : '0;

endmodule

// File: rtl/rpn_stack_unit.sv
module rpn_stack_unit #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_op,
    input  logic [ADDR_W-1:0] in_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] tos,
    output logic              busy,
    output logic              err_overflow,
    output logic              err_underflow,
    output logic              err_divzero
);
    import rpn_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);

    unit_state_t      state_q, state_d;
    logic             fire, is_push, is_pop, is_alu, is_div;
    logic             f_ovf, f_unf, f_dz, clean;
    logic [CNT_W-1:0] stk_count;
    logic [DATA_W-1:0] s_top, s_second, alu_res, st_wdata, div_q;
    logic             st_push, st_pop, st_fold, div_start, div_done;

    assign fire    = in_valid && in_ready;
    assign is_push = (in_op == OPC_PUSH);
    assign is_pop  = (in_op == OPC_POP);
    assign is_div  = (in_op == OPC_DIV);
    assign is_alu  = (in_op == OPC_ADD) || (in_op == OPC_SUB) || (in_op == OPC_MUL);

    assign f_ovf = fire && is_push && (stk_count == CNT_W'(DEPTH));
    assign f_unf = fire && ((is_pop && stk_count == '0) ||
                            ((is_alu || is_div) && stk_count < CNT_W'(2)));
    assign f_dz  = fire && is_div && !f_unf && (s_top == '0);
    assign clean = fire && !f_ovf && !f_unf && !f_dz;

    always_comb begin
        unique case (in_op)
            OPC_ADD: alu_res = s_second + s_top;
            OPC_SUB: alu_res = s_second - s_top;
            default: alu_res = s_second * s_top;
        endcase
    end

    assign div_start = clean && is_div;
    assign st_push   = clean && is_push;
    assign st_pop    = clean && is_pop;
    assign st_fold   = (clean && is_alu) || (state_q == ST_DIVIDE && div_done);
    assign st_wdata  = (state_q == ST_DIVIDE) ? div_q : (is_push ? mem_rdata : alu_res);

    rpn_stack #(.W(DATA_W), .DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_en (st_push),
        .pop_en  (st_pop),
        .fold_en (st_fold),
        .wdata   (st_wdata),
        .top     (s_top),
        .second  (s_second),
        .count   (stk_count)
    );

    rpn_divider #(.W(DATA_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (s_second),
        .divisor  (s_top),
        .done     (div_done),
        .quotient (div_q)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (div_start) state_d = ST_DIVIDE;
            ST_DIVIDE: if (div_done)  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs: status of the last accepted instruction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_overflow  <= 1'b0;
            err_underflow <= 1'b0;
            err_divzero   <= 1'b0;
        end else if (fire) begin
            err_overflow  <= f_ovf;
            err_underflow <= f_unf;
            err_divzero   <= f_dz;
        end
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign busy      = (state_q == ST_DIVIDE);
    assign tos       = s_top;
    assign mem_addr  = in_addr;
    assign mem_we    = st_pop;
    assign mem_wdata = s_top;

endmodule

// File: rtl/rpn_stack_unit_chk.sv
module rpn_stack_unit_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [2:0]        in_op,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] tos,
    input logic              busy,
    input logic              err_overflow,
    input logic              err_underflow,
    input logic              err_divzero,
    input logic [CNT_W-1:0]  depth
);
    a_r2_push_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 3'd0 && depth < CNT_W'(DEPTH))
        |=> tos == $past(mem_rdata));

    a_r3_write_only_pop: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (in_valid && in_ready && in_op == 3'd1 && depth != '0));

    a_r5_busy_after_div: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid && in_ready && in_op == 3'd5));

    a_r6_ovf_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overflow) |-> ($past(in_valid && in_op == 3'd0) && depth == $past(depth)));

    a_r7_unf_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_underflow) |-> depth == $past(depth));

    a_r8_dz_from_div: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_divzero) |-> ($past(in_valid && in_op == 3'd5) && depth == $past(depth)));

    a_r9_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_overflow, err_underflow, err_divzero}));

endmodule

bind rpn_stack_unit rpn_stack_unit_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_op         (in_op),
    .mem_we        (mem_we),
    .mem_rdata     (mem_rdata),
    .tos           (tos),
    .busy          (busy),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow),
    .err_divzero   (err_divzero),
    .depth         (stk_count)
);

// File: tb/rpn_stack_unit_test.sv
module rpn_stack_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 16;
    localparam int AW  = 4;
    localparam int DEP = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic [2:0]    in_op;
    logic [AW-1:0] in_addr;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata, mem_rdata, tos;
    logic          busy, err_overflow, err_underflow, err_divzero;

    logic          pre_we;
    logic [AW-1:0] pre_addr;
    logic [DW-1:0] pre_data;
    logic [DW-1:0] mem [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rpn_stack_unit #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DEP)) uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
        .in_op (in_op), .in_addr (in_addr), .mem_addr (mem_addr), .mem_we (mem_we),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .tos (tos), .busy (busy),
        .err_overflow (err_overflow), .err_underflow (err_underflow),
        .err_divzero (err_divzero)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (mem_we)      mem[mem_addr] <= mem_wdata;
        else if (pre_we) mem[pre_addr] <= pre_data;
    end

    typedef struct {
        string       tag;
        logic [15:0] tos;
        logic [2:0]  fl;
    } exp_t;

    exp_t sbq[$];
    event cmp_ev;
    int   total = 0;
    int   bad   = 0;

    logic signed [15:0] ms [DEP];
    int                 mc = 0;
    logic [15:0]        mm [16];

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compares each completed instruction against the scoreboard
    initial begin
        forever begin
            @(cmp_ev);
            if (sbq.size() != 0) begin
                exp_t e;
                e = sbq.pop_front();
                check(e.tag, "tos", {16'h0, tos}, {16'h0, e.tos});
                check(e.tag, "flags", {29'h0, err_overflow, err_underflow, err_divzero},
                      {29'h0, e.fl});
            end
        end
    end

    task automatic preload(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
        mm[a] = d;
    endtask

    // Driver: updates the reference model, queues the expectation, drives the handshake
    task automatic issue(logic [2:0] op, logic [3:0] a, string tag);
        exp_t e;
        logic [2:0] fl = 3'b000;
        logic signed [15:0] l, r, res;
        int q;
        int low = 0;
        res = '0;
        case (op)
            3'd0: if (mc == DEP) fl = 3'b100; else begin ms[mc] = mm[a]; mc++; end
            3'd1: if (mc == 0) fl = 3'b010; else begin mc--; mm[a] = ms[mc]; end
            3'd2, 3'd3, 3'd4, 3'd5: begin
                if (mc < 2) fl = 3'b010;
                else begin
                    l = ms[mc-2];
                    r = ms[mc-1];
                    if (op == 3'd5 && r == 0) fl = 3'b001;
                    else begin
                        case (op)
                            3'd2: res = l + r;
                            3'd3: res = l - r;
                            3'd4: res = l * r;
                            default: begin q = int'(l) / int'(r); res = 16'(q); end
                        endcase
                        ms[mc-2] = res;
                        mc--;
                    end
                end
            end
            default: ;
        endcase
        e.tag = tag;
        e.fl  = fl;
        e.tos = (mc > 0) ? ms[mc-1] : 16'h0;
        sbq.push_back(e);

        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        while (!in_ready && low < 100) begin
            low++;
            @(negedge clk);
        end
        if (op == 3'd5 && fl == 3'b000) check("R5", "ready-low cycles", low, DW + 1);
        else check(tag, "ready-low cycles", low, 0);
        ->cmp_ev;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_addr = '0;
        pre_we = 1'b0; pre_addr = '0; pre_data = '0;
        for (int i = 0; i < 16; i++) begin mem[i] = 16'h0; mm[i] = 16'h0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "tos", {16'h0, tos}, 0);
        check("R1", "ready/busy", {30'h0, in_ready, busy}, 2);
        check("R1", "flags", {29'h0, err_overflow, err_underflow, err_divzero}, 0);

        preload(4'd0, 16'd20);
        preload(4'd1, 16'd6);
        preload(4'd2, 16'hFFF9);  // -7
        preload(4'd3, 16'd3);
        preload(4'd4, 16'd0);
        preload(4'd5, 16'h8000);
        preload(4'd6, 16'hFFFF);  // -1
        preload(4'd7, 16'd300);
        preload(4'd8, 16'd250);

        // R11: (a-b)/c stored at x
        issue(3'd0, 4'd0, "R2");
        issue(3'd0, 4'd1, "R2");
        issue(3'd3, 4'd0, "R4");
        issue(3'd0, 4'd3, "R2");
        issue(3'd5, 4'd0, "R5");
        issue(3'd1, 4'd9, "R3");
        check("R11", "M[9]", {16'h0, mem[9]}, 4);

        // R4 MULT wraps, ADD with negative, R5 negative divisor
        issue(3'd0, 4'd7, "R2");
        issue(3'd0, 4'd8, "R2");
        issue(3'd4, 4'd0, "R4");
        issue(3'd0, 4'd2, "R2");
        issue(3'd2, 4'd0, "R4");
        issue(3'd0, 4'd2, "R2");
        issue(3'd5, 4'd0, "R5");
        issue(3'd1, 4'd10, "R3");

        // R5 negative dividend truncates toward zero; extreme quotient
        issue(3'd0, 4'd2, "R2");
        issue(3'd0, 4'd3, "R2");
        issue(3'd5, 4'd0, "R5");
        issue(3'd0, 4'd5, "R2");
        issue(3'd0, 4'd6, "R2");
        issue(3'd5, 4'd0, "R5");
        // R8 divide by zero leaves stack as is
        issue(3'd0, 4'd4, "R2");
        issue(3'd5, 4'd0, "R8");
        // R10 unused opcodes, R9 flags cleared
        issue(3'd6, 4'd0, "R10");
        issue(3'd7, 4'd11, "R10");
        issue(3'd1, 4'd11, "R3");
        issue(3'd1, 4'd12, "R3");
        issue(3'd1, 4'd13, "R3");

        // R7 underflow cases on an empty and a one-entry stack
        issue(3'd1, 4'd14, "R7");
        issue(3'd2, 4'd0, "R7");
        issue(3'd0, 4'd1, "R9");
        issue(3'd3, 4'd0, "R7");
        issue(3'd5, 4'd0, "R7");
        issue(3'd1, 4'd14, "R3");

        // R6 overflow at DEPTH entries, then drain to confirm contents
        for (int k = 0; k < DEP; k++) issue(3'd0, 4'(k), "R2");
        issue(3'd0, 4'd9, "R6");
        issue(3'd6, 4'd0, "R9");
        for (int k = 0; k < DEP; k++) issue(3'd1, 4'd15, "R6");
        issue(3'd1, 4'd15, "R7");

        // Final memory image
        for (int i = 0; i < 16; i++) check("R3", "memory word", {16'h0, mem[i]}, {16'h0, mm[i]});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule